// File: doc/BRIEF.md
# Serial Clock Prescaler Generator

This block derives the serial clock for an external memory from the kernel clock. It divides the kernel clock by an integer factor. Each serial period begins with a low phase and ends with a high phase. When the period length is odd, the low phase is the longer of the two. A command sequencer raises a run request while a transfer needs the clock. A free-run input keeps the clock toggling when no command is active. When neither input is set, the clock rests at a level chosen by the idle-level select: low for mode 0, high for mode 3.

Two single-cycle strobes mark each rising and each falling transition of the serial clock. The downstream shift and sample logic uses them and does not need to detect edges itself. The block reads the divider value and the run request only at period boundaries, so the serial clock never shows a shortened phase.

Top module: `serclk_gen`

## Requirements
- R1: A serial period lasts `div_ratio + 1` kernel cycles when `div_ratio` is 1 to 255. When `div_ratio` is 0, the period lasts 2 kernel cycles: one low and one high.
- R2: Within a period of N kernel cycles, `sclk` is low for ceil(N/2) cycles and then high for floor(N/2) cycles. With odd N the low phase is therefore one cycle longer.
- R3: `rise_stb` is high for exactly the first kernel cycle in which `sclk` is 1 after being 0. `fall_stb` is high for exactly the first cycle in which `sclk` is 0 after being 1. No strobe is high at any other time.
- R4: While no period is running, `sclk` follows `idle_high` with one cycle of latency: 0 rests the clock low (mode 0) and 1 rests it high (mode 3). While `idle_high` is held, no strobe occurs.
- R5: With `free_run` = 1 and `run_req` = 0, the clock toggles continuously with the period and duty cycle of R1 and R2.
- R6: A period starts on the first clock edge at which `run_req` or `free_run` is sampled high while parked. The first rising strobe then appears ceil(N/2) + 1 kernel edges after the request is applied.
- R7: A new `div_ratio` takes effect only from the next period boundary. The period in progress completes with its original length.
- R8: When both `run_req` and `free_run` are removed, the current period completes. The clock then parks at the `idle_high` level and produces no further edge.
- R9: During reset, `sclk`, `rise_stb` and `fall_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_ratio | input | DIV_W | Prescaler value; period = value + 1 (minimum 2) |
| idle_high | input | 1 | Resting level: 0 = low (mode 0), 1 = high (mode 3) |
| free_run | input | 1 | Keep the clock toggling without a command |
| run_req | input | 1 | Clock request from the command sequencer |
| sclk | output | 1 | Serial clock level |
| rise_stb | output | 1 | One-cycle pulse on each rising transition of sclk |
| fall_stb | output | 1 | One-cycle pulse on each falling transition of sclk |

## Verification
The divider is swept over every value from 0 to 31 and over the edge values 63, 64, 127, 128, 200, 254 and 255. For each value, the high and low phase lengths are measured and compared with floor and ceiling of half the period. Even and odd values separate the duty-cycle rule. The values 0 and 1 separate the minimum-period rule from plain division.

Further cases cover the boundary behaviour:
- A divider change just after a rising edge distinguishes applying the value at the period boundary from applying it immediately.
- Removing the request in mid high phase, with each idle level, distinguishes completing the period from stopping at once.
- A start from rest with mode 3 checks the start latency.
- Free running without a request checks continuous toggling.

A running monitor compares every strobe with the observed level history of `sclk`.

// File: rtl/serclk_pkg.sv
// Shared definitions for the serial clock generator.
// Assumes: the divider field width is fixed per instance through DIV_W.
package serclk_pkg;
    localparam int DIV_W_DEF = 8;

    // Sequencer state: parked at idle level or running a period
    typedef enum logic {
        ST_PARK = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;
endpackage

// File: rtl/serclk_period_cnt.sv
// Period sequencer: counts kernel cycles within one serial period.
// It latches the period length only at period start, and it decides
// at each period boundary whether to continue or to park.
// Assumes: run_en is already the OR of request and free-run.
module serclk_period_cnt
    import serclk_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEF,
    localparam int CNT_W = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_ratio,
    input  logic             run_en,
    output run_st_e          st_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] len_q,
    output run_st_e          st_nxt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic [CNT_W-1:0] len_nxt
);
    localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);

    logic [CNT_W-1:0] eff_len;
    logic             at_end;

    // Effective period length, never shorter than two kernel cycles
    always_comb begin
        if (div_ratio == '0) eff_len = MIN_LEN;
        else                 eff_len = {1'b0, div_ratio} + CNT_W'(1);
    end

    assign at_end = (cnt_q == len_q - CNT_W'(1));

    // Next-state decision: start, advance, restart or park
    always_comb begin
        st_nxt  = st_q;
        cnt_nxt = cnt_q;
        len_nxt = len_q;
        case (st_q)
            ST_PARK: begin
                if (run_en) begin
                    st_nxt  = ST_RUN;
                    cnt_nxt = '0;
                    len_nxt = eff_len;
                end
            end
            default: begin
                if (at_end) begin
                    cnt_nxt = '0;
                    if (run_en) len_nxt = eff_len;
                    else        st_nxt  = ST_PARK;
                end else begin
                    cnt_nxt = cnt_q + CNT_W'(1);
                end
            end
        endcase
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_PARK;
            cnt_q <= '0;
            len_q <= MIN_LEN;
        end else begin
            st_q  <= st_nxt;
            cnt_q <= cnt_nxt;
            len_q <= len_nxt;
        end
    end
endmodule

// File: rtl/serclk_wave.sv
// Waveform stage: turns the next sequencer state into a registered
// clock level and registered edge strobes, so all outputs are
// glitch-free flops.
// Assumes: within a period the low phase comes first and lasts
// ceil(len/2) cycles.
module serclk_wave
    import serclk_pkg::*;
#(
    parameter int CNT_W = DIV_W_DEF + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_high,
    input  run_st_e          st_nxt,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] len_nxt,
    output logic             sclk,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [CNT_W-1:0] low_len;
    logic             lvl_nxt;

    // Low-phase length rounds up so odd periods stay low longer
    assign low_len = CNT_W'((len_nxt + CNT_W'(1)) >> 1);

    // Level for the coming cycle: phase position or resting level
    always_comb begin
        if (st_nxt == ST_RUN) lvl_nxt = (cnt_nxt >= low_len);
        else                  lvl_nxt = idle_high;
    end

    // Output level and edge strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk     <= 1'b0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            sclk     <= lvl_nxt;
            rise_stb <= lvl_nxt & ~sclk;
            fall_stb <= ~lvl_nxt & sclk;
        end
    end
endmodule

// File: rtl/serclk_gen.sv
// Serial clock prescaler generator top.
// It divides the kernel clock by div_ratio+1 (minimum 2) and parks at
// a selectable level between commands. It also provides edge strobes.
// Assumes: all inputs are synchronous to clk.
module serclk_gen
    import serclk_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEF,
    localparam int CNT_W = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_ratio,
    input  logic             idle_high,
    input  logic             free_run,
    input  logic             run_req,
    output logic             sclk,
    output logic             rise_stb,
    output logic             fall_stb
);
    run_st_e          st_q, st_nxt;
    logic [CNT_W-1:0] cnt_q, len_q, cnt_nxt, len_nxt;
    logic             run_en;
    logic             run_active;

    // A period runs on a command or in free-run
    assign run_en     = run_req | free_run;
    assign run_active = (st_q == ST_RUN);

    serclk_period_cnt #(.DIV_W(DIV_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_ratio (div_ratio),
        .run_en    (run_en),
        .st_q      (st_q),
        .cnt_q     (cnt_q),
        .len_q     (len_q),
        .st_nxt    (st_nxt),
        .cnt_nxt   (cnt_nxt),
        .len_nxt   (len_nxt)
    );

    serclk_wave #(.CNT_W(CNT_W)) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle_high (idle_high),
        .st_nxt    (st_nxt),
        .cnt_nxt   (cnt_nxt),
        .len_nxt   (len_nxt),
        .sclk      (sclk),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb)
    );
endmodule

// File: rtl/serclk_gen_chk.sv
// Property checker for serclk_gen, attached through bind.
// Assumes: synchronous active-low reset on the checked block.
module serclk_gen_chk #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idle_high,
    input logic             sclk,
    input logic             rise_stb,
    input logic             fall_stb,
    input logic             run_active,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] len
);
    logic seen_q;

    // Marks that at least one cycle has passed since reset release
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R3
    rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && rise_stb) |-> (sclk && !$past(sclk)));

    // R3
    fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && fall_stb) |-> (!sclk && $past(sclk)));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));

    // R4
    park_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !run_active) |-> (sclk == $past(idle_high)));

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_active |-> ((cnt < len) && (len >= CNT_W'(2))));

    // R7
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && run_active && (cnt != '0)) |-> $stable(len));
endmodule

bind serclk_gen serclk_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle_high  (idle_high),
    .sclk       (sclk),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .run_active (run_active),
    .cnt        (cnt_q),
    .len        (len_q)
);

// File: tb/serclk_gen_tb.sv
// Self-checking bench for serclk_gen. It sweeps the divider and
// measures phase lengths from the outputs.
module serclk_gen_tb;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_ratio = '0;
    logic             idle_high = 1'b0;
    logic             free_run = 1'b0;
    logic             run_req = 1'b0;
    logic             sclk, rise_stb, fall_stb;

    int n_run = 0;
    int n_fail = 0;
    int strobe_err = 0;
    logic prev_s = 1'b0;
    logic mon_on = 1'b0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    serclk_gen #(.DIV_W(DIV_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_ratio (div_ratio),
        .idle_high (idle_high),
        .free_run  (free_run),
        .run_req   (run_req),
        .sclk      (sclk),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb)
    );

    // Strobe monitor: every strobe must match the observed level history (R3)
    always @(negedge clk) begin
        if (mon_on) begin
            if (rise_stb !== (sclk && !prev_s)) strobe_err++;
            if (fall_stb !== (!sclk && prev_s)) strobe_err++;
        end
        prev_s = sclk;
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rise(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rise_stb && n < 1000);
    endtask

    // Counts samples while sclk stays at lvl, starting from the current sample
    task automatic count_lvl(input logic lvl, output int n);
        n = 1;
        forever begin
            @(negedge clk);
            if (sclk != lvl || n >= 1000) break;
            n++;
        end
    endtask

    // Counts strobes over a window of cycles
    task automatic quiet_window(input int cyc, output int rises, output int falls, output int bad_lvl, input logic lvl);
        rises = 0; falls = 0; bad_lvl = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (rise_stb) rises++;
            if (fall_stb) falls++;
            if (sclk != lvl) bad_lvl++;
        end
    endtask

    // Watchdog
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int n, hi, lo, r, f, b, per;
        int divs[$];

        // R9: reset values
        repeat (3) @(negedge clk);
        check("R9 sclk", int'(sclk), 0);
        check("R9 strobes", int'(rise_stb) + int'(fall_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        prev_s = sclk;
        mon_on = 1'b1;

        // R4: rest low, then switch to rest high
        quiet_window(20, r, f, b, 1'b0);
        check("R4 low rest strobes", r + f, 0);
        check("R4 low rest level", b, 0);
        idle_high = 1'b1;
        @(negedge clk);
        check("R4 follows idle_high", int'(sclk), 1);
        quiet_window(20, r, f, b, 1'b1);
        check("R4 high rest strobes", r + f, 0);
        check("R4 high rest level", b, 0);

        // R6: start from mode 3 rest, div 4 -> N=5, low phase 3
        div_ratio = 8'd4;
        run_req = 1'b1;
        @(negedge clk);
        check("R6 first sample low", int'(sclk), 0);
        check("R6 first sample fall strobe", int'(fall_stb), 1);
        n = 1;
        while (!rise_stb && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check("R6 start latency", n, 3 + 1);

        // R1, R2: divider sweep
        idle_high = 1'b0;
        for (int d = 0; d < 32; d++) divs.push_back(d);
        divs.push_back(63); divs.push_back(64); divs.push_back(127);
        divs.push_back(128); divs.push_back(200); divs.push_back(254);
        divs.push_back(255);
        foreach (divs[k]) begin
            div_ratio = DIV_W'(divs[k]);
            per = (divs[k] == 0) ? 2 : divs[k] + 1;
            wait_rise(n);
            wait_rise(n);
            count_lvl(1'b1, hi);
            count_lvl(1'b0, lo);
            check($sformatf("R2 high div=%0d", divs[k]), hi, per / 2);
            check($sformatf("R2 low div=%0d", divs[k]), lo, per - per / 2);
            check($sformatf("R1 period div=%0d", divs[k]), hi + lo, per);
        end

        // R7: change divider right after a rise, N 10 -> 4
        div_ratio = 8'd9;
        wait_rise(n);
        wait_rise(n);
        div_ratio = 8'd3;
        count_lvl(1'b1, hi);
        check("R7 old high phase kept", hi, 5);
        count_lvl(1'b0, lo);
        check("R7 new low phase", lo, 2);
        count_lvl(1'b1, hi);
        check("R7 new high phase", hi, 2);

        // R8: stop in the high phase, rest low
        div_ratio = 8'd9;
        wait_rise(n);
        wait_rise(n);
        run_req = 1'b0;
        count_lvl(1'b1, hi);
        check("R8 period completes (low rest)", hi, 5);
        quiet_window(40, r, f, b, 1'b0);
        check("R8 parked low no rise", r + f, 0);
        check("R8 parked low level", b, 0);

        // R8: stop in the high phase, rest high
        idle_high = 1'b1;
        @(negedge clk);
        run_req = 1'b1;
        wait_rise(n);
        run_req = 1'b0;
        quiet_window(40, r, f, b, 1'b1);
        check("R8 parked high no edge", r + f, 0);
        check("R8 parked high level", b, 0);

        // R5: free run without request, div 2 -> high 1, low 2
        idle_high = 1'b0;
        div_ratio = 8'd2;
        free_run = 1'b1;
        wait_rise(n);
        check("R5 free run starts", int'(n < 1000), 1);
        count_lvl(1'b1, hi);
        count_lvl(1'b0, lo);
        check("R5 free run high", hi, 1);
        check("R5 free run low", lo, 2);
        free_run = 1'b0;
        repeat (10) @(negedge clk);

        check("R3 strobe alignment errors", strobe_err, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule